// File: doc/BRIEF.md
# Checkpoint and Rollback Sequencer

This block is a control sequencer that keeps a region of reconfigurable logic healthy without changing the logic inside it. The region is described by `N_FRAMES` configuration frames. The sequencer scrubs the frames in the background. It reads one frame at a time through an abstract frame-access port and tests the syndrome returned for that frame. Between frames it can take a snapshot of the region's flip-flop state: it captures the flip-flops into configuration memory, reads every frame back and saves it to safe storage. When a scanned frame turns out to be corrupt, it rolls the region back to the last good snapshot.

Safe storage holds two snapshot banks. A new snapshot always goes into the bank that does not hold the last good one. It becomes the good one only if every frame read back during that snapshot was clean and matched its golden image once the flip-flop bits were masked out. The golden comparison is done outside the block and arrives as a single flag with each readback.

Three streams use valid/ready: the frame command stream, the readback response stream and the storage command stream. A command is taken on a cycle where both valid and ready are high. While valid is high and ready is low, the sequencer holds the command and all its fields steady. The environment may hold ready low for any number of cycles, and the sequencer simply waits. The sequencer raises `rb_ready` only while it is waiting for the response to its own read. Status pins are plain levels or pulses.

Top module: `ckrb_sequencer`

## Requirements
- R1: During reset and on leaving it, no command is presented, `fault_cnt` is 0 and `ckpt_valid` and `fatal` are 0. Before any scan read, the sequencer first takes an initial snapshot into bank 0.
- R2: Scanning reads frames one at a time in round-robin order 0, 1, ..., N_FRAMES-1, 0, ... and skips none. A read is issued only after the previous response has been accepted. Any nonzero `rb_syndrome` marks the whole frame as faulty. No bit is ever corrected.
- R3: A snapshot issues these frame commands in order: UNMASK, then CAPTURE, then for each frame i from 0 upward a READ of i followed by a storage save (`st_save`=1) of i, then MASK. The `fa_op` codes are READ=0, WRITE=1, UNMASK=2, MASK=3, CAPTURE=4 and RESTORE=5.
- R4: A rollback issues these commands in order: for each frame i from 0 upward a storage load (`st_save`=0) of i from the good bank followed by a WRITE of i, then UNMASK, then RESTORE, then MASK.
- R5: A snapshot becomes pending when either `PERIOD` scan cycles have passed since the last snapshot or rollback started, or `ckpt_req` is sampled high. A pending snapshot starts only at a frame boundary, that is, after a scan response.
- R6: A faulty scan frame starts a rollback at once and cancels any pending snapshot. When the rollback completes, exactly one fresh snapshot runs and scanning then resumes.
- R7: A snapshot writes bank `~good` (`st_bank` value). If every readback in it has a zero syndrome and `rb_golden_ok`=1, it becomes the good bank and `ckpt_valid` rises. If not, the good bank and `ckpt_valid` stay unchanged.
- R8: Scanning resumes after a snapshot or rollback at the frame that follows the last one scanned.
- R9: A command held without ready keeps its valid and fields stable. A frame command and a storage command are never presented in the same cycle.
- R10: `busy` is high during initialisation, snapshots and rollbacks, and low while scanning. `rec_done` is a one-cycle pulse when a rollback ends. `fault_cnt` adds one per faulty scan frame and saturates at its maximum.
- R11: A faulty scan frame found while no valid snapshot exists raises `fatal`. `fatal` then stays high and no further command is issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ckpt_req | input | 1 | External snapshot request, sampled each cycle |
| fa_valid | output | 1 | Frame command valid |
| fa_ready | input | 1 | Frame command accepted |
| fa_op | output | 3 | Frame command code (R3) |
| fa_idx | output | IDX_W | Frame index for READ and WRITE, 0 otherwise |
| rb_valid | input | 1 | Readback response valid |
| rb_ready | output | 1 | Sequencer waiting for a readback response |
| rb_syndrome | input | SYN_W | Error syndrome of the frame read |
| rb_golden_ok | input | 1 | Frame matches golden image with flip-flop bits masked |
| st_valid | output | 1 | Storage command valid |
| st_ready | input | 1 | Storage command accepted |
| st_save | output | 1 | 1 = save frame to storage, 0 = load frame from storage |
| st_bank | output | 1 | Storage bank of the command |
| st_idx | output | IDX_W | Frame index of the storage command |
| busy | output | 1 | Initialising, taking a snapshot or rolling back |
| ckpt_valid | output | 1 | A good snapshot exists |
| rec_done | output | 1 | One-cycle pulse at the end of a rollback |
| fault_cnt | output | CNT_W | Saturating count of faulty scan frames |
| fatal | output | 1 | Fault found with no good snapshot |

## Verification
The bench records every accepted command on the frame and storage ports while its responder stalls ready on a fixed pattern. It then checks each snapshot and rollback event by event against the order and bank it computes itself. It places a scan fault right where a snapshot request is also raised. A design that lets the request survive would run a second snapshot after the post-rollback one, and a design that lets the snapshot win would save the corrupt frame. It injects a golden mismatch into a snapshot and then forces a rollback. A design that commits the bad snapshot would load the wrong bank. It also walks the scan index across the wrap and around every snapshot and rollback, so a skipped or restarted index shows up, and it makes the initial snapshot invalid so that the first fault must end in `fatal` and no further commands.

// File: rtl/ckrb_pkg.sv
package ckrb_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_UNMASK  = 3'd2,
    OP_MASK    = 3'd3,
    OP_CAPTURE = 3'd4,
    OP_RESTORE = 3'd5
  } frame_op_e;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_C_UNMASK,
    ST_C_CAPT,
    ST_C_RD,
    ST_C_RSP,
    ST_C_SAVE,
    ST_C_MASK,
    ST_S_RD,
    ST_S_RSP,
    ST_R_LOAD,
    ST_R_WR,
    ST_R_UNMASK,
    ST_R_REST,
    ST_R_MASK,
    ST_FATAL
  } seq_state_e;

endpackage

// File: rtl/ckrb_cursor.sv
module ckrb_cursor #(
  parameter int N_FRAMES = 4,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end
  end

  assign idx  = idx_q;
  assign last = (idx_q == LAST_IDX);

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && last) |=> (idx == '0));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !last) |=> (idx == $past(idx) + IDX_W'(1)));

endmodule

// File: rtl/ckrb_trigger.sv
module ckrb_trigger #(
  parameter int PERIOD = 1000,
  localparam int TW = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic req,
  input  logic clr,
  output logic pend
);

  localparam logic [TW-1:0] TLAST = TW'(PERIOD - 1);

  logic [TW-1:0] tmr_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (req) pend_q <= 1'b1;
      if (run && !pend_q) begin
        if (tmr_q == TLAST) pend_q <= 1'b1;
        else                tmr_q  <= tmr_q + TW'(1);
      end
    end
  end

  assign pend = pend_q;

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);

endmodule

// File: rtl/ckrb_fault_cnt.sv
module ckrb_fault_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (inc && ~&cnt_q)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && ~&cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc || &cnt) |=> $stable(cnt));

endmodule

// File: rtl/ckrb_sequencer.sv
module ckrb_sequencer
  import ckrb_pkg::*;
#(
  parameter int N_FRAMES = 4,
  parameter int SYN_W    = 12,
  parameter int PERIOD   = 1000,
  parameter int CNT_W    = 16,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckpt_req,
  output logic             fa_valid,
  input  logic             fa_ready,
  output logic [2:0]       fa_op,
  output logic [IDX_W-1:0] fa_idx,
  input  logic             rb_valid,
  output logic             rb_ready,
  input  logic [SYN_W-1:0] rb_syndrome,
  input  logic             rb_golden_ok,
  output logic             st_valid,
  input  logic             st_ready,
  output logic             st_save,
  output logic             st_bank,
  output logic [IDX_W-1:0] st_idx,
  output logic             busy,
  output logic             ckpt_valid,
  output logic             rec_done,
  output logic [CNT_W-1:0] fault_cnt,
  output logic             fatal
);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] sidx, xidx;
  logic             slast, xlast;
  logic             s_adv, x_adv;
  logic             pend, trig_clr, scanning;
  logic             bad_q, good_q, valid_q, rdone_q;
  logic             frame_bad, scan_rsp, scan_fault;

  assign frame_bad  = (rb_syndrome != '0);
  assign scan_rsp   = (state_q == ST_S_RSP) && rb_valid;
  assign scan_fault = scan_rsp && frame_bad;
  assign scanning   = (state_q == ST_S_RD) || (state_q == ST_S_RSP);

  ckrb_cursor #(.N_FRAMES(N_FRAMES)) scan_cur_i (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .adv(s_adv), .idx(sidx), .last(slast)
  );

  ckrb_cursor #(.N_FRAMES(N_FRAMES)) xfer_cur_i (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_INIT), .adv(x_adv),
    .idx(xidx), .last(xlast)
  );

  ckrb_trigger #(.PERIOD(PERIOD)) trig_i (
    .clk(clk), .rst_n(rst_n), .run(scanning), .req(ckpt_req),
    .clr(trig_clr), .pend(pend)
  );

  ckrb_fault_cnt #(.CNT_W(CNT_W)) fcnt_i (
    .clk(clk), .rst_n(rst_n), .inc(scan_fault), .cnt(fault_cnt)
  );

  assign s_adv = scan_rsp;
  assign x_adv = ((state_q == ST_C_SAVE) && st_ready) ||
                 ((state_q == ST_R_WR) && fa_ready);

  // snapshot or rollback start cancels anything pending
  assign trig_clr = (state_q == ST_INIT) ||
                    (scan_rsp && (frame_bad || pend)) ||
                    ((state_q == ST_R_MASK) && fa_ready);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:     state_d = ST_C_UNMASK;
      ST_C_UNMASK: if (fa_ready) state_d = ST_C_CAPT;
      ST_C_CAPT:   if (fa_ready) state_d = ST_C_RD;
      ST_C_RD:     if (fa_ready) state_d = ST_C_RSP;
      ST_C_RSP:    if (rb_valid) state_d = ST_C_SAVE;
      ST_C_SAVE:   if (st_ready) state_d = xlast ? ST_C_MASK : ST_C_RD;
      ST_C_MASK:   if (fa_ready) state_d = ST_S_RD;
      ST_S_RD:     if (fa_ready) state_d = ST_S_RSP;
      ST_S_RSP: begin
        if (rb_valid) begin
          if (frame_bad)  state_d = valid_q ? ST_R_LOAD : ST_FATAL;
          else if (pend)  state_d = ST_C_UNMASK;
          else            state_d = ST_S_RD;
        end
      end
      ST_R_LOAD:   if (st_ready) state_d = ST_R_WR;
      ST_R_WR:     if (fa_ready) state_d = xlast ? ST_R_UNMASK : ST_R_LOAD;
      ST_R_UNMASK: if (fa_ready) state_d = ST_R_REST;
      ST_R_REST:   if (fa_ready) state_d = ST_R_MASK;
      ST_R_MASK:   if (fa_ready) state_d = ST_C_UNMASK;
      ST_FATAL:    state_d = ST_FATAL;
      default:     state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      bad_q   <= 1'b0;
      good_q  <= 1'b1;
      valid_q <= 1'b0;
      rdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rdone_q <= (state_q == ST_R_MASK) && fa_ready;
      if (state_q == ST_C_CAPT) begin
        bad_q <= 1'b0;
      end else if ((state_q == ST_C_RSP) && rb_valid &&
                   (frame_bad || !rb_golden_ok)) begin
        bad_q <= 1'b1;
      end
      if ((state_q == ST_C_MASK) && fa_ready && !bad_q) begin
        good_q  <= ~good_q;
        valid_q <= 1'b1;
      end
    end
  end

  always_comb begin
    fa_valid = 1'b1;
    fa_op    = OP_READ;
    fa_idx   = '0;
    unique case (state_q)
      ST_C_UNMASK, ST_R_UNMASK: fa_op = OP_UNMASK;
      ST_C_MASK, ST_R_MASK:     fa_op = OP_MASK;
      ST_C_CAPT:                fa_op = OP_CAPTURE;
      ST_R_REST:                fa_op = OP_RESTORE;
      ST_C_RD:                  fa_idx = xidx;
      ST_S_RD:                  fa_idx = sidx;
      ST_R_WR: begin
        fa_op  = OP_WRITE;
        fa_idx = xidx;
      end
      default:                  fa_valid = 1'b0;
    endcase
  end

  assign st_valid   = (state_q == ST_C_SAVE) || (state_q == ST_R_LOAD);
  assign st_save    = (state_q == ST_C_SAVE);
  assign st_bank    = st_save ? ~good_q : good_q;
  assign st_idx     = xidx;
  assign rb_ready   = (state_q == ST_C_RSP) || (state_q == ST_S_RSP);
  assign busy       = !(scanning || (state_q == ST_FATAL));
  assign fatal      = (state_q == ST_FATAL);
  assign ckpt_valid = valid_q;
  assign rec_done   = rdone_q;

  // R9
  fa_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_valid && !fa_ready) |=> (fa_valid && $stable(fa_op) && $stable(fa_idx)));

  // R9
  st_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=>
      (st_valid && $stable(st_save) && $stable(st_bank) && $stable(st_idx)));

  // R9
  always_comb begin
    port_excl_chk: assert (!(fa_valid && st_valid));
  end

  // R11
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && !fa_valid && !st_valid));

  // R11
  fatal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fault && !ckpt_valid) |=> fatal);

  // R10
  rec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  // R6
  rec_then_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> (fa_valid && fa_op == OP_UNMASK));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_valid |=> ckpt_valid);

endmodule

// File: tb/ckrb_sequencer_tb_top.sv
`timescale 1ns/1ps
module ckrb_sequencer_tb_top;

  localparam int N      = 4;
  localparam int SYN_W  = 8;
  localparam int PER    = 60;
  localparam int IW     = 2;
  localparam int LIMIT  = 150000;

  localparam logic [3:0] K_READ = 4'd0, K_WRITE = 4'd1, K_UNMASK = 4'd2,
                         K_MASK = 4'd3, K_CAPT = 4'd4, K_REST = 4'd5,
                         K_SAVE = 4'd6, K_LOAD = 4'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ckpt_req;
  logic fa_valid, fa_ready;
  logic [2:0] fa_op;
  logic [IW-1:0] fa_idx;
  logic rb_valid, rb_ready, rb_golden_ok;
  logic [SYN_W-1:0] rb_syndrome;
  logic st_valid, st_ready, st_save, st_bank;
  logic [IW-1:0] st_idx;
  logic busy, ckpt_valid, rec_done, fatal;
  logic [15:0] fault_cnt;

  always #4 clk = ~clk;

  ckrb_sequencer #(.N_FRAMES(N), .SYN_W(SYN_W), .PERIOD(PER), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ckpt_req(ckpt_req),
    .fa_valid(fa_valid), .fa_ready(fa_ready), .fa_op(fa_op), .fa_idx(fa_idx),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_syndrome(rb_syndrome),
    .rb_golden_ok(rb_golden_ok),
    .st_valid(st_valid), .st_ready(st_ready), .st_save(st_save),
    .st_bank(st_bank), .st_idx(st_idx),
    .busy(busy), .ckpt_valid(ckpt_valid), .rec_done(rec_done),
    .fault_cnt(fault_cnt), .fatal(fatal)
  );

  // responder and log state, owned by the posedge block
  int          cyc = 0;
  logic [15:0] ev [0:2047];
  int          ev_n = 0;
  int          rec_cnt = 0;
  logic        rd_pend = 1'b0;
  int          rd_dly = 0;
  logic [SYN_W-1:0] rd_syn = '0;
  logic        rd_gok = 1'b1;
  logic        req_hit = 1'b0;
  int          flt_seen = 0, gm_seen = 0;

  // stimulus controls, owned by the initial block
  logic        req_task = 1'b0;
  logic        hit_req = 1'b0;
  int          flt_tok = 0, gm_tok = 0;
  int          flt_idx = 0, gm_idx = 0;

  assign ckpt_req = req_task | req_hit;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rd_pend = 1'b0;
      req_hit = 1'b0;
    end else begin
      if (req_hit) req_hit = 1'b0;
      if (rb_valid && rb_ready) rd_pend = 1'b0;
      else if (rd_pend && rd_dly > 0) rd_dly = rd_dly - 1;
      if (fa_valid && fa_ready) begin
        if (ev_n < 2048) ev[ev_n] = {1'b0, fa_op, 4'd0, 6'd0, fa_idx};
        ev_n = ev_n + 1;
        if (fa_op == 3'd0) begin
          rd_pend = 1'b1;
          rd_dly  = 1;
          rd_syn  = '0;
          rd_gok  = 1'b1;
          if (!busy && flt_tok != flt_seen && int'(fa_idx) == flt_idx) begin
            rd_syn   = 8'h24;
            flt_seen = flt_tok;
            if (hit_req) req_hit = 1'b1;
          end
          if (busy && gm_tok != gm_seen && int'(fa_idx) == gm_idx) begin
            rd_gok  = 1'b0;
            gm_seen = gm_tok;
          end
        end
      end
      if (st_valid && st_ready) begin
        if (ev_n < 2048) ev[ev_n] = {st_save ? K_SAVE : K_LOAD, 3'd0, st_bank, 6'd0, st_idx};
        ev_n = ev_n + 1;
      end
      if (rec_done) rec_cnt = rec_cnt + 1;
    end
  end

  always @(negedge clk) begin
    fa_ready     <= (cyc % 4) != 1;
    st_ready     <= (cyc % 3) != 2;
    rb_valid     <= rd_pend && (rd_dly == 0);
    rb_syndrome  <= rd_syn;
    rb_golden_ok <= rd_gok;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ev(input int n);
    while (ev_n < n && cyc < LIMIT) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] k, input int b, input int i);
    return {k, 4'(b), 8'(i)};
  endfunction

  task automatic chk_ev(input int p, input logic [15:0] exp, input string tag);
    check(ev[p] == exp, tag, int'(ev[p]), int'(exp));
  endtask

  task automatic chk_ckpt(inout int p, input int bank, input string tag);
    wait_ev(p + 2*N + 3);
    chk_ev(p, mk(K_UNMASK, 0, 0), tag);
    chk_ev(p + 1, mk(K_CAPT, 0, 0), tag);
    for (int i = 0; i < N; i++) begin
      chk_ev(p + 2 + 2*i, mk(K_READ, 0, i), tag);
      chk_ev(p + 3 + 2*i, mk(K_SAVE, bank, i), tag);
    end
    chk_ev(p + 2 + 2*N, mk(K_MASK, 0, 0), tag);
    p = p + 2*N + 3;
  endtask

  task automatic chk_rec(inout int p, input int bank, input string tag);
    wait_ev(p + 2*N + 3);
    for (int i = 0; i < N; i++) begin
      chk_ev(p + 2*i, mk(K_LOAD, bank, i), tag);
      chk_ev(p + 1 + 2*i, mk(K_WRITE, 0, i), tag);
    end
    chk_ev(p + 2*N, mk(K_UNMASK, 0, 0), tag);
    chk_ev(p + 2*N + 1, mk(K_REST, 0, 0), tag);
    chk_ev(p + 2*N + 2, mk(K_MASK, 0, 0), tag);
    p = p + 2*N + 3;
  endtask

  // walk consecutive scan reads, checking round-robin order (R2, R8)
  task automatic walk(inout int p, inout int e, output int nrd);
    nrd = 0;
    forever begin
      wait_ev(p + 1);
      if (cyc >= LIMIT || ev[p][15:12] != K_READ || nrd > 200) break;
      check(int'(ev[p][7:0]) == e, "R2 scan order", int'(ev[p][7:0]), e);
      e = (e + 1) % N;
      p++;
      nrd++;
    end
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req_task = 1'b1;
    @(negedge clk);
    req_task = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int p, e, nrd, fc, rc, fidx, base;

    // R1: reset state
    repeat (5) @(negedge clk);
    check(fa_valid == 0 && st_valid == 0, "R1 no command in reset", {fa_valid, st_valid}, 0);
    check(fault_cnt == 0, "R1 fault_cnt reset", fault_cnt, 0);
    check(ckpt_valid == 0 && fatal == 0, "R1 status reset", {ckpt_valid, fatal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1, "R10 busy during init", busy, 1);
    check(ckpt_valid == 0, "R1 no valid before initial snapshot", ckpt_valid, 0);

    // R1 R3: initial snapshot into bank 0
    p = 0;
    chk_ckpt(p, 0, "R1 R3 initial snapshot");
    repeat (3) @(negedge clk);
    check(ckpt_valid == 1, "R7 initial snapshot committed", ckpt_valid, 1);
    check(busy == 0, "R10 busy low while scanning", busy, 0);

    // R5: periodic snapshot, scan keeps round-robin (R2, R8)
    e = 0;
    walk(p, e, nrd);
    check(nrd >= N, "R2 full round before timer", nrd, N);
    chk_ckpt(p, 1, "R5 periodic snapshot bank 1");
    wait_ev(p + 1);
    check(int'(ev[p][7:0]) == e && ev[p][15:12] == K_READ, "R8 resume after snapshot",
          int'(ev[p]), e);

    // R5: requested snapshot at a frame boundary
    pulse_req();
    walk(p, e, nrd);
    check(nrd <= 3, "R5 request served at next boundary", nrd, 3);
    chk_ckpt(p, 0, "R5 requested snapshot bank 0");

    // R6: fault with a request raised at the same time -> rollback, one snapshot
    fc = int'(fault_cnt);
    rc = rec_cnt;
    fidx = (e + 2) % N;
    flt_idx = fidx;
    hit_req = 1'b1;
    flt_tok++;
    walk(p, e, nrd);
    hit_req = 1'b0;
    check(int'(ev[p-1][7:0]) == fidx, "R2 faulty frame is last read", int'(ev[p-1][7:0]), fidx);
    chk_rec(p, 0, "R4 R6 rollback from bank 0");
    chk_ckpt(p, 1, "R6 fresh snapshot after rollback");
    wait_ev(p + 2);
    chk_ev(p, mk(K_READ, 0, e), "R6 R8 scan resumes, request cancelled");
    chk_ev(p + 1, mk(K_READ, 0, (e + 1) % N), "R6 no second snapshot");
    check(int'(fault_cnt) == fc + 1, "R10 fault_cnt step", fault_cnt, fc + 1);
    check(rec_cnt == rc + 1, "R10 one rec_done pulse", rec_cnt, rc + 1);
    e = (e + 2) % N;
    p = p + 2;

    // R7: golden mismatch leaves bank 1 as the good one
    gm_idx = 2;
    gm_tok++;
    pulse_req();
    walk(p, e, nrd);
    chk_ckpt(p, 0, "R7 invalid snapshot written to bank 0");
    repeat (3) @(negedge clk);
    check(ckpt_valid == 1, "R7 valid flag kept", ckpt_valid, 1);
    flt_idx = (e + 1) % N;
    flt_tok++;
    walk(p, e, nrd);
    chk_rec(p, 1, "R7 rollback still uses bank 1");
    chk_ckpt(p, 0, "R7 next snapshot targets bank 0");

    // R11: invalid initial snapshot then fault -> fatal
    do_reset();
    base = ev_n;
    gm_idx = 1;
    gm_tok++;
    flt_idx = 0;
    flt_tok++;
    rc = rec_cnt;
    @(negedge clk);
    rst_n = 1'b1;
    p = base;
    chk_ckpt(p, 0, "R11 initial snapshot (invalid)");
    wait_ev(p + 1);
    chk_ev(p, mk(K_READ, 0, 0), "R11 first scan read");
    repeat (60) @(negedge clk);
    check(ev_n == p + 1, "R11 no command after fatal", ev_n, p + 1);
    check(fatal == 1, "R11 fatal raised", fatal, 1);
    check(ckpt_valid == 0, "R11 no valid snapshot", ckpt_valid, 0);
    check(fault_cnt == 1, "R10 R11 fault counted", fault_cnt, 1);
    check(rec_cnt == rc, "R11 no rollback", rec_cnt, rc);

    if (cyc >= LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule